// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the control port of a video display controller. Every 16-bit word written there is either a single-word internal register write or one half of a two-word access command. The block tells the two apart, keeps the half-finished command across other port traffic, and turns a completed command into an access target and direction (the access kind), a 17-bit memory address and a one-cycle DMA start pulse for a separate DMA engine.

Register writes are forwarded to a register file outside the block as a one-cycle write pulse. Only the two register values the decoder needs are kept inside: two mode bits (extended mode, DMA enable) and the auto-increment step. Each access on the data port steps the address by that increment. During a data port write the block also masks the write data for the two narrow 64-entry tables and provides the table index.

Top module: `vdc_ctrl_decoder`

## Requirements
- R1: After reset the pending flag is 0, the access kind is 0, the address is 0, and neither dma_start nor reg_wr_en is asserted.
- R2: A control word with bits 15:14 = 2'b10, written with no command pending, is a register write: index = bits 12:8, value = bits 7:0. When it is accepted, reg_wr_en pulses one cycle later with that index and value. The access kind becomes 0 whether or not the write is accepted, and the address is kept.
- R3: While register 1 bit 2 (extended mode) is 0, a register write with index above 10 is dropped. There is no reg_wr_en pulse, and a write to register 15 leaves the increment unchanged.
- R4: Any other control word written with no command pending is stored as the upper half (hi) of the command and sets cmd_pending. The kind and the address do not change.
- R5: The control write that follows completes the command with the lower half (lo) and clears cmd_pending. The kind becomes {lo[5:4], hi[15:14]}: 1 VRAM write, 3 CRAM write, 5 VSRAM write, 0 VRAM read, 8 CRAM read, 4 VSRAM read, 12 VRAM byte read. The address becomes {lo[2], lo[1:0], hi[13:0]}.
- R6: While register 1 bit 4 (DMA enable) is 0, bit 7 of the lower half is not taken from the written word: it keeps the value of bit 7 of the previous lower half.
- R7: dma_start is high for exactly one cycle, right after a completing write whose effective lower-half bit 7 is 1.
- R8: A status read or a data access made while a command is pending applies the command formed by the new upper half and the previous lower half, and clears cmd_pending.
- R9: Each data access adds register 15 to address bits 15:0. A carry out of bit 15 toggles address bit 16. This happens for every access kind, and a pending command is applied before the step.
- R10: During a data access, mem_wdata is dat_wdata AND 0x0EEE for kind 3, dat_wdata AND 0x07FF for kind 5, and dat_wdata unchanged otherwise. mem_index is address bits 6:1 of the access.
- R11: While a command is pending, a word with bits 15:14 = 2'b10 completes the command. It is not treated as a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control port write strobe |
| ctl_wdata | input | 16 | Control port write word |
| stat_rd | input | 1 | Status read strobe |
| dat_acc | input | 1 | Data port access strobe (read or write) |
| dat_wdata | input | 16 | Data port write word |
| acc_kind | output | 4 | Decoded access kind |
| acc_addr | output | 17 | Current access address |
| cmd_pending | output | 1 | Upper command half held |
| dma_start | output | 1 | One-cycle DMA request |
| reg_wr_en | output | 1 | Accepted register write pulse |
| reg_wr_idx | output | 5 | Register index of the pulse |
| reg_wr_val | output | 8 | Register value of the pulse |
| mem_wdata | output | 16 | Masked data for the current access |
| mem_index | output | 6 | Table index for the current access |

## Verification
On every cycle the assertions check the pending-flag protocol: it is set by an upper half, cleared by a completing write, and cleared by a status read or data access. They also check that dma_start is a single-cycle pulse, that bit 7 is kept while DMA is disabled, that a register write zeroes the kind, that a high-index write in legacy mode leaves the increment alone, and the distance of each address step. The field layout of the access kind and address, the CRAM and VSRAM masks, carries into bit 16 across a range of increments, and the way a partial command is formed from a stale lower half can only be shown by the bench's sweeps, which compare against values it works out from the words it wrote.

// File: rtl/vdc_pkg.sv
package vdc_pkg;
   localparam int CMD_W  = 32;
   localparam int WORD_W = 16;
   localparam int ADDR_W = 17;
   localparam int KIND_W = 4;

   localparam logic [KIND_W-1:0] K_CRAM_WR  = 4'd3;
   localparam logic [KIND_W-1:0] K_VSRAM_WR = 4'd5;

   typedef struct packed {
      logic [KIND_W-1:0] kind;
      logic [ADDR_W-1:0] addr;
   } cmd_view_t;

   // Gather the scattered kind and address fields of a full command.
   function automatic cmd_view_t view_of(input logic [CMD_W-1:0] c);
      cmd_view_t v;
      v.kind = {c[5:4], c[31:30]};
      v.addr = {c[2], c[1:0], c[29:16]};
      return v;
   endfunction

   function automatic logic is_reg_word(input logic [WORD_W-1:0] w);
      return w[15:14] == 2'b10;
   endfunction
endpackage

// File: rtl/vdc_reg_bank.sv
module vdc_reg_bank #(
   parameter int NUM_REGS    = 32,
   parameter int REG_W       = 8,
   parameter int LEGACY_LAST = 10,
   parameter int MODE_REG    = 1,
   parameter int EXT_BIT     = 2,
   parameter int DMAEN_BIT   = 4,
   parameter int INC_REG     = 15,
   localparam int IDX_W      = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [REG_W-1:0] wr_val,
   output logic             wr_ok,
   output logic             ext_mode,
   output logic             dma_en,
   output logic [REG_W-1:0] inc
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEGACY_LAST);
   localparam logic [IDX_W-1:0] MODE_IDX = IDX_W'(MODE_REG);
   localparam logic [IDX_W-1:0] INC_IDX  = IDX_W'(INC_REG);

   if (EXT_BIT >= REG_W || DMAEN_BIT >= REG_W) begin : g_bad_bits
      $error("mode bit positions exceed register width");
   end
   if (MODE_REG >= NUM_REGS || INC_REG >= NUM_REGS || LEGACY_LAST >= NUM_REGS) begin : g_bad_idx
      $error("register indices exceed register count");
   end

   logic ext_q, dma_q;
   logic [REG_W-1:0] inc_q;

   always_comb wr_ok = wr_req && ((wr_idx <= LAST_IDX) || ext_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_q <= 1'b0;
         dma_q <= 1'b0;
         inc_q <= '0;
      end else if (wr_ok) begin
         if (wr_idx == MODE_IDX) begin
            ext_q <= wr_val[EXT_BIT];
            dma_q <= wr_val[DMAEN_BIT];
         end
         if (wr_idx == INC_IDX) inc_q <= wr_val;
      end
   end

   assign ext_mode = ext_q;
   assign dma_en   = dma_q;
   assign inc      = inc_q;

   // R3: high-index writes in legacy mode leave the increment alone
   a_r3_legacy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !ext_q && (wr_idx > LAST_IDX) |=> $stable(inc_q));
endmodule

// File: rtl/vdc_cmd_assembler.sv
module vdc_cmd_assembler
   import vdc_pkg::*;
#(
   parameter bit DMA_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [WORD_W-1:0] ctl_wdata,
   input  logic              stat_rd,
   input  logic              dat_acc,
   input  logic              dma_en,
   output logic              reg_req,
   output logic              apply,
   output cmd_view_t         view,
   output logic              pending,
   output logic [KIND_W-1:0] kind,
   output logic              dma_start
);
   logic [CMD_W-1:0]  cmd_q, cmd_next;
   logic [WORD_W-1:0] lo_eff;
   logic pend_q, kind_clr, hi_take, lo_take, side_apply;
   logic [KIND_W-1:0] kind_q;
   logic dma_q;

   // Bit 7 of the lower half: gated by DMA enable, or passed straight through.
   if (DMA_GATE) begin : g_gate
      always_comb begin
         lo_eff    = ctl_wdata;
         lo_eff[7] = dma_en ? ctl_wdata[7] : cmd_q[7];
      end
   end else begin : g_pass
      always_comb lo_eff = ctl_wdata;
   end

   always_comb begin
      reg_req    = ctl_wr && !pend_q && is_reg_word(ctl_wdata);
      hi_take    = ctl_wr && !pend_q && !is_reg_word(ctl_wdata);
      lo_take    = ctl_wr && pend_q;
      side_apply = !ctl_wr && pend_q && (stat_rd || dat_acc);
      kind_clr   = reg_req;
      apply      = lo_take || side_apply;
      cmd_next   = cmd_q;
      if (hi_take) cmd_next[CMD_W-1:WORD_W] = ctl_wdata;
      if (lo_take) cmd_next[WORD_W-1:0]     = lo_eff;
      view = view_of(cmd_next);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         pend_q <= 1'b0;
         kind_q <= '0;
         dma_q  <= 1'b0;
      end else begin
         cmd_q <= cmd_next;
         dma_q <= lo_take && lo_eff[7];
         if (hi_take)    pend_q <= 1'b1;
         else if (apply) pend_q <= 1'b0;
         if (apply)         kind_q <= view.kind;
         else if (kind_clr) kind_q <= '0;
      end
   end

   assign pending   = pend_q;
   assign kind      = kind_q;
   assign dma_start = dma_q;

   // R4: an upper half leaves the block pending
   a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && !pend_q && (ctl_wdata[15:14] != 2'b10) |=> pend_q);
   // R11: any word written while pending completes the command
   a_r11_complete: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && pend_q |=> !pend_q);
   // R8: status read or data access flushes the partial command
   a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr && pend_q && (stat_rd || dat_acc) |=> !pend_q);
   // R7: the request is a single-cycle pulse
   a_r7_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dma_q |=> !dma_q);

   if (DMA_GATE) begin : g_gate_chk
      // R6: with DMA disabled the request follows the kept bit 7
      a_r6_bit7_kept: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_wr && pend_q && !dma_en |=> dma_q == $past(cmd_q[7]));
   end
endmodule

// File: rtl/vdc_addr_stepper.sv
module vdc_addr_stepper #(
   parameter int ADDR_W = 17,
   parameter int INC_W  = 8,
   localparam int LOW_W = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   input  logic [INC_W-1:0]  inc,
   output logic [ADDR_W-1:0] addr
);
   if (INC_W > LOW_W) begin : g_bad_inc
      $error("increment wider than the stepped address part");
   end

   logic [ADDR_W-1:0] addr_q, base;
   logic [LOW_W:0]    sum;

   always_comb begin
      base = load ? load_addr : addr_q;
      sum  = {1'b0, base[LOW_W-1:0]} + (LOW_W+1)'(inc);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    addr_q <= '0;
      else if (step) addr_q <= {base[ADDR_W-1] ^ sum[LOW_W], sum[LOW_W-1:0]};
      else if (load) addr_q <= load_addr;
   end

   assign addr = addr_q;

   // R9: the low part moves by exactly the increment
   a_r9_step_dist: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load |=> (addr_q[LOW_W-1:0] - $past(addr_q[LOW_W-1:0])) == LOW_W'($past(inc)));
   // R9: a wrap of the low part flips the top address bit
   a_r9_carry_flip: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && sum[LOW_W] |=> addr_q[ADDR_W-1] != $past(addr_q[ADDR_W-1]));
endmodule

// File: rtl/vdc_data_mask.sv
module vdc_data_mask
   import vdc_pkg::*;
#(
   parameter bit              MASK_EN    = 1'b1,
   parameter logic [WORD_W-1:0] CRAM_MASK  = 16'h0EEE,
   parameter logic [WORD_W-1:0] VSRAM_MASK = 16'h07FF,
   parameter int              TBL_AW     = 6
) (
   input  logic [KIND_W-1:0] kind,
   input  logic [TBL_AW-1:0] index_in,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] mem_wdata,
   output logic [TBL_AW-1:0] mem_index
);
   if (TBL_AW < 1 || TBL_AW > 15) begin : g_bad_aw
      $error("table index width out of range");
   end

   if (MASK_EN) begin : g_mask
      always_comb begin
         unique case (kind)
            K_CRAM_WR:  mem_wdata = wdata & CRAM_MASK;
            K_VSRAM_WR: mem_wdata = wdata & VSRAM_MASK;
            default:    mem_wdata = wdata;
         endcase
      end
   end else begin : g_raw
      logic [KIND_W-1:0] kind_unused;
      always_comb kind_unused = kind;
      always_comb mem_wdata = wdata;
   end

   assign mem_index = index_in;

   // R10: masked words never carry bits outside their table's mask
   always_comb begin
      if (MASK_EN && kind == K_CRAM_WR)
         a_r10_cram_mask: assert ((mem_wdata & ~CRAM_MASK) == '0);
      if (MASK_EN && kind == K_VSRAM_WR)
         a_r10_vsram_mask: assert ((mem_wdata & ~VSRAM_MASK) == '0);
   end
endmodule

// File: rtl/vdc_ctrl_decoder.sv
module vdc_ctrl_decoder
   import vdc_pkg::*;
#(
   parameter int              NUM_REGS    = 32,
   parameter int              REG_W       = 8,
   parameter int              LEGACY_LAST = 10,
   parameter int              MODE_REG    = 1,
   parameter int              EXT_BIT     = 2,
   parameter int              DMAEN_BIT   = 4,
   parameter int              INC_REG     = 15,
   parameter bit              DMA_GATE    = 1'b1,
   parameter bit              MASK_EN     = 1'b1,
   parameter logic [15:0]     CRAM_MASK   = 16'h0EEE,
   parameter logic [15:0]     VSRAM_MASK  = 16'h07FF,
   parameter int              TBL_AW      = 6,
   localparam int             IDX_W       = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [15:0]       ctl_wdata,
   input  logic              stat_rd,
   input  logic              dat_acc,
   input  logic [15:0]       dat_wdata,
   output logic [3:0]        acc_kind,
   output logic [16:0]       acc_addr,
   output logic              cmd_pending,
   output logic              dma_start,
   output logic              reg_wr_en,
   output logic [IDX_W-1:0]  reg_wr_idx,
   output logic [REG_W-1:0]  reg_wr_val,
   output logic [15:0]       mem_wdata,
   output logic [TBL_AW-1:0] mem_index
);
   if (IDX_W > 5 || NUM_REGS != (1 << IDX_W)) begin : g_bad_regs
      $error("register count must be a power of two fitting five index bits");
   end
   if (REG_W != 8) begin : g_bad_w
      $error("register value field is eight bits wide");
   end

   logic reg_req, reg_ok, apply, ext_mode, dma_en;
   logic [REG_W-1:0] inc;
   cmd_view_t view;
   logic [KIND_W-1:0] eff_kind;
   logic [TBL_AW-1:0] eff_index;
   logic flush_now;

   vdc_cmd_assembler #(.DMA_GATE(DMA_GATE)) u_asm (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .stat_rd(stat_rd), .dat_acc(dat_acc), .dma_en(dma_en),
      .reg_req(reg_req), .apply(apply), .view(view),
      .pending(cmd_pending), .kind(acc_kind), .dma_start(dma_start)
   );

   vdc_reg_bank #(
      .NUM_REGS(NUM_REGS), .REG_W(REG_W), .LEGACY_LAST(LEGACY_LAST),
      .MODE_REG(MODE_REG), .EXT_BIT(EXT_BIT), .DMAEN_BIT(DMAEN_BIT), .INC_REG(INC_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_req(reg_req), .wr_idx(ctl_wdata[8 +: IDX_W]), .wr_val(ctl_wdata[REG_W-1:0]),
      .wr_ok(reg_ok), .ext_mode(ext_mode), .dma_en(dma_en), .inc(inc)
   );

   vdc_addr_stepper #(.ADDR_W(ADDR_W), .INC_W(REG_W)) u_step (
      .clk(clk), .rst_n(rst_n),
      .load(apply), .load_addr(view.addr),
      .step(dat_acc && !ctl_wr), .inc(inc), .addr(acc_addr)
   );

   // A data access that flushes a pending command uses the freshly applied target.
   always_comb begin
      flush_now = apply && !ctl_wr && dat_acc;
      eff_kind  = flush_now ? view.kind : acc_kind;
      eff_index = flush_now ? view.addr[TBL_AW:1] : acc_addr[TBL_AW:1];
   end

   vdc_data_mask #(
      .MASK_EN(MASK_EN), .CRAM_MASK(CRAM_MASK), .VSRAM_MASK(VSRAM_MASK), .TBL_AW(TBL_AW)
   ) u_mask (
      .kind(eff_kind), .index_in(eff_index), .wdata(dat_wdata),
      .mem_wdata(mem_wdata), .mem_index(mem_index)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_wr_en  <= 1'b0;
         reg_wr_idx <= '0;
         reg_wr_val <= '0;
      end else begin
         reg_wr_en <= reg_ok;
         if (reg_ok) begin
            reg_wr_idx <= ctl_wdata[8 +: IDX_W];
            reg_wr_val <= ctl_wdata[REG_W-1:0];
         end
      end
   end

   logic ext_unused;
   always_comb ext_unused = ext_mode;

   // R2: any register word zeroes the access kind
   a_r2_kind_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req |=> acc_kind == '0);
   // R2: a register word keeps the address
   a_r2_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req |=> $stable(acc_addr));
   // R3: a dropped write produces no pulse
   a_r3_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && !reg_ok |=> !reg_wr_en);
endmodule

// File: tb/sim_vdc_ctrl_decoder.sv
module sim_vdc_ctrl_decoder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0, stat_rd = 1'b0, dat_acc = 1'b0;
   logic [15:0] ctl_wdata = '0, dat_wdata = '0;
   logic [3:0]  acc_kind;
   logic [16:0] acc_addr;
   logic cmd_pending, dma_start, reg_wr_en;
   logic [4:0]  reg_wr_idx;
   logic [7:0]  reg_wr_val;
   logic [15:0] mem_wdata;
   logic [5:0]  mem_index;

   always #4 clk = ~clk;

   vdc_ctrl_decoder u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .stat_rd(stat_rd), .dat_acc(dat_acc), .dat_wdata(dat_wdata),
      .acc_kind(acc_kind), .acc_addr(acc_addr), .cmd_pending(cmd_pending),
      .dma_start(dma_start), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
      .reg_wr_val(reg_wr_val), .mem_wdata(mem_wdata), .mem_index(mem_index)
   );

   int nchk = 0, nfail = 0;
   bit done = 0;

   // bench model state
   logic [31:0] m_cmd = '0;
   logic        m_pend = 1'b0;
   logic [3:0]  m_kind = '0;
   logic [16:0] m_addr = '0;
   logic [7:0]  m_r1 = '0, m_r15 = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic m_apply();
      m_kind = {m_cmd[5:4], m_cmd[31:30]};
      m_addr = {m_cmd[2], m_cmd[1:0], m_cmd[29:16]};
   endtask

   task automatic chk_state(input string tag);
      chk({tag, " kind"}, 32'(acc_kind), 32'(m_kind));
      chk({tag, " addr"}, 32'(acc_addr), 32'(m_addr));
      chk({tag, " pending"}, 32'(cmd_pending), 32'(m_pend));
   endtask

   task automatic ctl(input logic [15:0] w, input string tag);
      logic exp_reg = 1'b0;
      logic exp_dma = 1'b0;
      logic [15:0] lo;
      logic [4:0] ri;
      if (m_pend) begin
         lo = w;
         if (!m_r1[4]) lo[7] = m_cmd[7];
         m_cmd[15:0] = lo;
         m_pend = 1'b0;
         m_apply();
         exp_dma = lo[7];
      end else if (w[15:14] == 2'b10) begin
         m_kind = '0;
         ri = w[12:8];
         if (ri <= 5'd10 || m_r1[2]) begin
            exp_reg = 1'b1;
            if (ri == 5'd1)  m_r1  = w[7:0];
            if (ri == 5'd15) m_r15 = w[7:0];
         end
      end else begin
         m_cmd[31:16] = w;
         m_pend = 1'b1;
      end
      @(negedge clk) begin ctl_wr = 1'b1; ctl_wdata = w; end
      @(negedge clk) ctl_wr = 1'b0;
      chk_state(tag);
      chk({tag, " dma_start"}, 32'(dma_start), 32'(exp_dma));
      chk({tag, " reg_wr_en"}, 32'(reg_wr_en), 32'(exp_reg));
      if (exp_reg) begin
         chk({tag, " reg_wr_idx"}, 32'(reg_wr_idx), 32'(w[12:8]));
         chk({tag, " reg_wr_val"}, 32'(reg_wr_val), 32'(w[7:0]));
      end
   endtask

   task automatic dat(input logic [15:0] d, input string tag);
      logic [16:0] s;
      logic [15:0] exp_d;
      if (m_pend) begin m_pend = 1'b0; m_apply(); end
      exp_d = (m_kind == 4'd3) ? (d & 16'h0EEE) : (m_kind == 4'd5) ? (d & 16'h07FF) : d;
      @(negedge clk) begin dat_acc = 1'b1; dat_wdata = d; end
      #1;
      chk({tag, " R10 mem_wdata"}, 32'(mem_wdata), 32'(exp_d));
      chk({tag, " R10 mem_index"}, 32'(mem_index), 32'(m_addr[6:1]));
      @(negedge clk) dat_acc = 1'b0;
      s = 17'(m_addr[15:0]) + 17'(m_r15);
      m_addr = {m_addr[16] ^ s[16], s[15:0]};
      chk_state(tag);
   endtask

   task automatic stat(input string tag);
      if (m_pend) begin m_pend = 1'b0; m_apply(); end
      @(negedge clk) stat_rd = 1'b1;
      @(negedge clk) stat_rd = 1'b0;
      chk_state(tag);
   endtask

   task automatic command(input logic [3:0] code, input logic [16:0] a, input logic b7, input string tag);
      ctl({code[1:0], a[13:0]}, tag);
      ctl({8'h00, b7, 1'b0, code[3:2], 1'b0, a[16], a[15:14]}, tag);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      logic [3:0]  codes [7] = '{4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd8, 4'd12};
      logic [16:0] addrs [5] = '{17'h00000, 17'h1FFFF, 17'h0ABCD, 17'h10001, 17'h04000};
      logic [7:0]  incs  [5] = '{8'h01, 8'h02, 8'h80, 8'hFF, 8'h00};

      repeat (3) @(negedge clk);
      // R1: reset state
      chk_state("R1 reset");
      chk("R1 reset dma_start", 32'(dma_start), 0);
      chk("R1 reset reg_wr_en", 32'(reg_wr_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1 after release");

      // R3: legacy-mode register sweep; register 1 keeps mode bits clear
      for (int i = 0; i < 32; i++)
         ctl({3'b100, 5'(i), (i == 1) ? 8'h00 : (8'hA5 ^ 8'(i))}, "R3 legacy sweep");
      command(4'd1, 17'h00100, 1'b0, "R5 cmd for R3");
      dat(16'h1234, "R3 increment unchanged");

      // R2: enable extended mode, sweep accepted writes
      ctl(16'h8104, "R2 mode write");
      for (int i = 11; i < 32; i++)
         if (i != 15) ctl({3'b100, 5'(i), 8'h3C ^ 8'(i)}, "R2 ext sweep");
      ctl(16'h8F02, "R2 increment write");
      chk("R2 kind zeroed", 32'(acc_kind), 0);

      // R5/R9/R10: access kinds, addresses and increments
      foreach (incs[k]) begin
         ctl({8'h8F, incs[k]}, "R9 increment set");
         foreach (codes[c]) foreach (addrs[a]) begin
            command(codes[c], addrs[a], 1'b0, "R5 kind/addr");
            dat(16'hFFFF, "R9 step");
            dat(16'h5A5A ^ 16'(a), "R9 second step");
         end
      end

      // R4/R8: partial commands flushed by status read and data access
      ctl(16'h8F04, "R9 increment 4");
      command(4'd5, 17'h1C002, 1'b0, "R5 base");
      ctl(16'h7123, "R4 upper half held");
      stat("R8 status flush");
      ctl(16'h0456, "R4 upper half again");
      dat(16'hFFFF, "R8 data flush");

      // R11: register-looking word completes a pending command
      ctl(16'h4010, "R4 upper before R11");
      ctl(16'h8031, "R11 completes command");

      // R2: register write keeps address and zeroes kind
      ctl(16'h8A77, "R2 clears kind keeps addr");

      // R6/R7: DMA gating of bit 7
      ctl(16'h8114, "R7 dma enable");
      command(4'd1, 17'h02000, 1'b1, "R7 dma request");
      ctl(16'h8104, "R6 dma disable");
      command(4'd3, 17'h00040, 1'b0, "R6 bit7 kept set");
      ctl(16'h8114, "R7 dma enable again");
      command(4'd1, 17'h00000, 1'b0, "R7 no request");
      ctl(16'h8104, "R6 dma disable again");
      command(4'd5, 17'h00022, 1'b1, "R6 bit7 kept clear");
      @(negedge clk);
      chk("R7 pulse ended", 32'(dma_start), 0);

      // R3: back to legacy, increment write dropped
      ctl(16'h8100, "R3 legacy again");
      ctl(16'h8F10, "R3 dropped increment");
      command(4'd1, 17'h0FFFE, 1'b0, "R5 cmd");
      dat(16'h0001, "R3 R9 old increment carries");

      summary();
   end
endmodule